// File: doc/BRIEF.md
# Soft-Start Reference Ramp Sequencer

This block sequences the start-up of a switching regulator controller. It takes digital flags for input supply good, enable good, thermal fault and overload, a one-cycle pulse for each switching cycle, and a digitized output-sense code. It produces the reference code that feeds the error-amplifier DAC. The code climbs linearly from zero to the regulation reference over a fixed number of switching cycles. The block also drives a switching enable, a soft-start-active flag that downstream logic uses to lower the error-amplifier gain, and a ramp-done flag.

The reference drops to zero and switching stops when the supply or enable flag falls, or when the thermal flag rises. After a thermal fault clears, a new ramp starts from zero. An overload freezes the ramp. When the overload goes away, the ramp restarts from the sensed output level rather than from zero, at the same slope, so the output rises back without overshoot. The analog loop, the comparators and the DAC are not part of this block.

Top module: `softstart_seq`

## Requirements
- R1: Starting from zero, after k switching ticks the reference code equals floor(REF_CODE*k/RAMP_TICKS). It reaches REF_CODE on tick RAMP_TICKS (1114) exactly and not earlier. The default REF_CODE is 3900.
- R2: The block leaves the off state only when vin_ok_i and en_ok_i are both high and therm_i is low. From reset, sw_en_o, ss_active_o, done_o and ref_code_o are all 0. The outputs follow the inputs sampled at a rising clock edge, one clock later.
- R3: If vin_ok_i or en_ok_i is low at an edge while the block is ramping or regulating, then after that edge sw_en_o is 0 and ref_code_o is 0. A later enable restarts the ramp from zero.
- R4: While therm_i is high, the block sits in the fault state with sw_en_o at 0 and ref_code_o at 0. Once therm_i clears, the block returns to off and starts a fresh ramp from zero if it is enabled.
- R5: While ovld_i is high in the ramp or regulate state, switching stays enabled and ticks are ignored, so ref_code_o holds.
- R6: On the first edge with ovld_i low after an overload, ref_code_o loads min(sense_i, REF_CODE) and the accumulator restarts. From there the code adds floor(REF_CODE*k/RAMP_TICKS) per k ticks, saturating at REF_CODE.
- R7: ref_code_o never exceeds REF_CODE. A sensed level at or above REF_CODE goes straight to regulate with ref_code_o equal to REF_CODE.
- R8: ss_active_o is high exactly in the ramp state and done_o exactly in the regulate state. They are never high together, and done_o implies ref_code_o equals REF_CODE.
- R9: During a ramp with no tick and no overload release, ref_code_o does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vin_ok_i | input | 1 | Input supply above its undervoltage threshold |
| en_ok_i | input | 1 | Enable above its start threshold |
| therm_i | input | 1 | Junction over-temperature flag |
| tick_i | input | 1 | One-clock pulse per switching cycle |
| ovld_i | input | 1 | Overload (current limit) active |
| sense_i | input | DAC_W | Digitized output-sense level |
| ref_code_o | output | DAC_W | Effective error-amplifier reference code |
| sw_en_o | output | 1 | Power switching allowed |
| ss_active_o | output | 1 | Soft-start ramp in progress |
| done_o | output | 1 | Ramp complete, regulating |

## Verification
A reference model computes every expected output each clock.

- **Full ramp with gaps:** a full ramp is driven with ticks every third clock, including a long stretch with no ticks. This separates a tick-counted ramp from a clock-counted one and catches an off-by-one at tick 1114.
- **Supply and enable gating:** supply-only and enable-only patterns show that both flags are needed to start.
- **Disable and thermal mid-ramp:** a disable and a thermal trip in the middle of a ramp tell a reset-to-zero apart from a pause.
- **Overload releases:** three overload releases are tried, from the regulate state, from mid-ramp at a lower sensed level, and at a sensed level above the reference. They tell a restart from the sensed level apart from a restart from zero, and check the clamp.

// File: rtl/ss_seq_pkg.sv
package ss_seq_pkg;

  typedef enum logic [1:0] {
    SS_OFF   = 2'd0,
    SS_RAMP  = 2'd1,
    SS_REG   = 2'd2,
    SS_FAULT = 2'd3
  } ss_state_e;

endpackage

// File: rtl/ss_ramp_acc.sv
// Reference ramp datapath: integer step plus a fractional remainder
// accumulator, so that REF_CODE is reached on exactly RAMP_TICKS ticks.
module ss_ramp_acc #(
  parameter int DAC_W      = 12,
  parameter int REF_CODE   = 3900,
  parameter int RAMP_TICKS = 1114
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             load_i,
  input  logic [DAC_W-1:0] start_i,
  input  logic             adv_i,
  output logic [DAC_W-1:0] code_o,
  output logic             sat_o
);

  localparam int STEP_Q = REF_CODE / RAMP_TICKS;
  localparam int STEP_R = REF_CODE % RAMP_TICKS;
  localparam int ACC_W  = $clog2(2 * RAMP_TICKS);
  localparam int SUM_W  = DAC_W + 1;

  localparam logic [ACC_W-1:0] TICKS_A = ACC_W'(RAMP_TICKS);
  localparam logic [ACC_W-1:0] REM_A   = ACC_W'(STEP_R);
  localparam logic [SUM_W-1:0] QUO_S   = SUM_W'(STEP_Q);
  localparam logic [SUM_W-1:0] REF_S   = SUM_W'(REF_CODE);
  localparam logic [DAC_W-1:0] REF_D   = DAC_W'(REF_CODE);

  logic [DAC_W-1:0] code_q, code_d;
  logic [ACC_W-1:0] acc_q, acc_d, acc_sum;
  logic             carry;
  logic [SUM_W-1:0] sum;
  logic             code_en;

  always_comb begin
    acc_sum = acc_q + REM_A;
    carry   = (acc_sum >= TICKS_A);
    sum     = {1'b0, code_q} + QUO_S + SUM_W'(carry);
    sat_o   = (sum >= REF_S);
  end

  always_comb begin
    code_d  = code_q;
    acc_d   = acc_q;
    code_en = clr_i | load_i | adv_i;
    if (clr_i) begin
      code_d = '0;
      acc_d  = '0;
    end else if (load_i) begin
      code_d = start_i;
      acc_d  = '0;
    end else if (adv_i) begin
      code_d = sat_o ? REF_D : sum[DAC_W-1:0];
      acc_d  = carry ? (acc_sum - TICKS_A) : acc_sum;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= '0;
      acc_q  <= '0;
    end else if (code_en) begin
      code_q <= code_d;
      acc_q  <= acc_d;
    end
  end

  assign code_o = code_q;

endmodule

// File: rtl/ss_seq_fsm.sv
// Sequencing state machine: power gating, thermal fault, overload hold/release.
module ss_seq_fsm
  import ss_seq_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      pwr_ok_i,
  input  logic      therm_i,
  input  logic      tick_i,
  input  logic      ovld_i,
  input  logic      start_full_i,
  input  logic      sat_i,
  output ss_state_e state_o,
  output logic      clr_o,
  output logic      load_o,
  output logic      adv_o
);

  ss_state_e st_q, st_d;
  logic      ovl_q, ovl_d;

  always_comb begin
    st_d   = st_q;
    ovl_d  = ovl_q;
    clr_o  = 1'b0;
    load_o = 1'b0;
    adv_o  = 1'b0;
    unique case (st_q)
      SS_OFF: begin
        clr_o = 1'b1;
        ovl_d = 1'b0;
        if (therm_i)       st_d = SS_FAULT;
        else if (pwr_ok_i) st_d = SS_RAMP;
      end
      SS_FAULT: begin
        clr_o = 1'b1;
        ovl_d = 1'b0;
        if (!therm_i) st_d = SS_OFF;
      end
      default: begin
        if (therm_i) begin
          clr_o = 1'b1;
          ovl_d = 1'b0;
          st_d  = SS_FAULT;
        end else if (!pwr_ok_i) begin
          clr_o = 1'b1;
          ovl_d = 1'b0;
          st_d  = SS_OFF;
        end else if (ovld_i) begin
          ovl_d = 1'b1;
        end else if (ovl_q) begin
          ovl_d  = 1'b0;
          load_o = 1'b1;
          st_d   = start_full_i ? SS_REG : SS_RAMP;
        end else if (st_q == SS_RAMP && tick_i) begin
          adv_o = 1'b1;
          if (sat_i) st_d = SS_REG;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= SS_OFF;
      ovl_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      ovl_q <= ovl_d;
    end
  end

  assign state_o = st_q;

endmodule

// File: rtl/ss_min_clamp.sv
// Lower of an input code and a fixed limit.
module ss_min_clamp #(
  parameter int W     = 12,
  parameter int LIMIT = 3900
) (
  input  logic [W-1:0] in_i,
  output logic [W-1:0] out_o
);

  localparam logic [W-1:0] LIM_W = W'(LIMIT);

  always_comb begin
    out_o = (in_i < LIM_W) ? in_i : LIM_W;
  end

endmodule

// File: rtl/softstart_seq.sv
module softstart_seq
  import ss_seq_pkg::*;
#(
  parameter int DAC_W      = 12,
  parameter int REF_CODE   = 3900,
  parameter int RAMP_TICKS = 1114
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             vin_ok_i,
  input  logic             en_ok_i,
  input  logic             therm_i,
  input  logic             tick_i,
  input  logic             ovld_i,
  input  logic [DAC_W-1:0] sense_i,
  output logic [DAC_W-1:0] ref_code_o,
  output logic             sw_en_o,
  output logic             ss_active_o,
  output logic             done_o
);

  localparam logic [DAC_W-1:0] REF_D = DAC_W'(REF_CODE);

  // asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  ss_state_e        state;
  logic             clr, load, adv, sat;
  logic [DAC_W-1:0] start_code, ramp_code;
  logic             start_full;

  ss_min_clamp #(.W(DAC_W), .LIMIT(REF_CODE)) u_start_clamp (
    .in_i  (sense_i),
    .out_o (start_code)
  );
  assign start_full = (start_code == REF_D);

  ss_seq_fsm u_fsm (
    .clk          (clk),
    .rst_n        (rst_int_n),
    .pwr_ok_i     (vin_ok_i & en_ok_i),
    .therm_i      (therm_i),
    .tick_i       (tick_i),
    .ovld_i       (ovld_i),
    .start_full_i (start_full),
    .sat_i        (sat),
    .state_o      (state),
    .clr_o        (clr),
    .load_o       (load),
    .adv_o        (adv)
  );

  ss_ramp_acc #(
    .DAC_W      (DAC_W),
    .REF_CODE   (REF_CODE),
    .RAMP_TICKS (RAMP_TICKS)
  ) u_ramp (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .clr_i   (clr),
    .load_i  (load),
    .start_i (start_code),
    .adv_i   (adv),
    .code_o  (ramp_code),
    .sat_o   (sat)
  );

  // effective reference: lower of the ramp and the fixed reference (R7)
  ss_min_clamp #(.W(DAC_W), .LIMIT(REF_CODE)) u_ref_clamp (
    .in_i  (ramp_code),
    .out_o (ref_code_o)
  );

  assign sw_en_o     = (state == SS_RAMP) || (state == SS_REG);
  assign ss_active_o = (state == SS_RAMP);
  assign done_o      = (state == SS_REG);

endmodule

// File: rtl/ss_seq_chk.sv
module ss_seq_chk #(
  parameter int DAC_W    = 12,
  parameter int REF_CODE = 3900
) (
  input logic             clk,
  input logic             rst_n,
  input logic             vin_ok_i,
  input logic             en_ok_i,
  input logic             therm_i,
  input logic             tick_i,
  input logic             ovld_i,
  input logic [DAC_W-1:0] ref_code_o,
  input logic             sw_en_o,
  input logic             ss_active_o,
  input logic             done_o
);

  localparam logic [DAC_W-1:0] REF_D = DAC_W'(REF_CODE);

  a_r3_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !(vin_ok_i && en_ok_i) |=> (!sw_en_o && ref_code_o == '0));

  a_r4_thermal_stops: assert property (@(posedge clk) disable iff (!rst_n)
    therm_i |=> (!sw_en_o && ref_code_o == '0));

  a_r8_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(ss_active_o && done_o));

  a_r8_done_at_ref: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (ref_code_o == REF_D));

  a_r7_never_above_ref: assert property (@(posedge clk) disable iff (!rst_n)
    ref_code_o <= REF_D);

  a_r1_ramp_monotonic: assert property (@(posedge clk) disable iff (!rst_n)
    (ss_active_o && $past(ss_active_o) && !$past(ovld_i, 2))
      |-> (ref_code_o >= $past(ref_code_o)));

  a_r9_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (ss_active_o && $past(ss_active_o) && !$past(tick_i) && !$past(ovld_i, 2))
      |-> $stable(ref_code_o));

  a_r5_overload_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (ovld_i && vin_ok_i && en_ok_i && !therm_i && sw_en_o)
      |=> (sw_en_o && $stable(ref_code_o)));

endmodule

bind softstart_seq ss_seq_chk #(.DAC_W(DAC_W), .REF_CODE(REF_CODE)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .vin_ok_i    (vin_ok_i),
  .en_ok_i     (en_ok_i),
  .therm_i     (therm_i),
  .tick_i      (tick_i),
  .ovld_i      (ovld_i),
  .ref_code_o  (ref_code_o),
  .sw_en_o     (sw_en_o),
  .ss_active_o (ss_active_o),
  .done_o      (done_o)
);

// File: tb/softstart_seq_tb.sv
`timescale 1ns/1ps
module softstart_seq_tb;

  localparam int DAC_W = 12;
  localparam int REF   = 3900;
  localparam int TICKS = 1114;

  localparam int M_OFF = 0;
  localparam int M_RMP = 1;
  localparam int M_REG = 2;
  localparam int M_FLT = 3;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             vin_ok, en_ok, therm, tick, ovld;
  logic [DAC_W-1:0] sense;
  logic [DAC_W-1:0] ref_code;
  logic             sw_en, ss_active, done;

  always #10 clk = ~clk;

  softstart_seq #(.DAC_W(DAC_W), .REF_CODE(REF), .RAMP_TICKS(TICKS)) u_dut (
    .clk (clk), .rst_n (rst_n), .vin_ok_i (vin_ok), .en_ok_i (en_ok),
    .therm_i (therm), .tick_i (tick), .ovld_i (ovld), .sense_i (sense),
    .ref_code_o (ref_code), .sw_en_o (sw_en), .ss_active_o (ss_active),
    .done_o (done)
  );

  typedef struct {
    int    code;
    bit    sw;
    bit    ss;
    bit    dn;
    string tag;
  } exp_t;

  exp_t  exp_q[$];
  int    n_checks = 0;
  int    n_errors = 0;
  bit    finished = 0;
  string cur_tag  = "R2 idle";

  int m_st = M_OFF, m_k = 0, m_start = 0, m_code = 0, tick_cnt = 0;
  bit m_ovl = 0;

  // monitor: compare each result one delta after the edge that produced it
  always @(posedge clk) begin
    #1;
    if (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      n_checks++;
      if (int'(ref_code) != e.code || sw_en != e.sw || ss_active != e.ss || done != e.dn) begin
        n_errors++;
        $display("FAIL %s: code=%0d sw=%0b ss=%0b done=%0b expected code=%0d sw=%0b ss=%0b done=%0b",
                 e.tag, ref_code, sw_en, ss_active, done, e.code, e.sw, e.ss, e.dn);
      end
    end
  end

  // driver: apply one cycle of inputs and push the model's expected result
  task automatic step(input bit v, input bit e, input bit t, input bit tk,
                      input bit ov, input int sn);
    exp_t x;
    @(negedge clk);
    vin_ok = v; en_ok = e; therm = t; tick = tk; ovld = ov; sense = DAC_W'(sn);
    case (m_st)
      M_OFF: begin
        m_ovl = 0;
        if (t) m_st = M_FLT;
        else if (v && e) begin m_st = M_RMP; m_k = 0; m_start = 0; m_code = 0; end
      end
      M_FLT: begin
        m_ovl = 0;
        if (!t) m_st = M_OFF;
      end
      default: begin
        if (t) begin m_st = M_FLT; m_code = 0; m_ovl = 0; end
        else if (!(v && e)) begin m_st = M_OFF; m_code = 0; m_ovl = 0; end
        else if (ov) m_ovl = 1;
        else if (m_ovl) begin
          m_ovl = 0; m_k = 0;
          m_start = (sn > REF) ? REF : sn;
          m_code  = m_start;
          m_st    = (m_start >= REF) ? M_REG : M_RMP;
        end else if (m_st == M_RMP && tk) begin
          m_k++;
          m_code = m_start + (REF * m_k) / TICKS;
          if (m_code >= REF) begin m_code = REF; m_st = M_REG; end
        end
      end
    endcase
    x.code = m_code;
    x.sw   = (m_st == M_RMP) || (m_st == M_REG);
    x.ss   = (m_st == M_RMP);
    x.dn   = (m_st == M_REG);
    x.tag  = cur_tag;
    exp_q.push_back(x);
  endtask

  // n cycles; per = 0 gives no ticks, else one tick every per cycles
  task automatic run(input int n, input bit v, input bit e, input bit t,
                     input bit ov, input int sn, input int per);
    for (int i = 0; i < n; i++) begin
      bit tk;
      tick_cnt++;
      tk = (per != 0) && (tick_cnt % per == 0);
      step(v, e, t, tk, ov, sn);
    end
  endtask

  task automatic run_to_done(input int sn);
    int guard = 0;
    while (m_st != M_REG && guard < 20000) begin
      run(1, 1, 1, 0, 0, sn, 3);
      guard++;
    end
    run(4, 1, 1, 0, 0, sn, 3);
  endtask

  initial begin
    rst_n = 1'b0;
    vin_ok = 0; en_ok = 0; therm = 0; tick = 0; ovld = 0; sense = '0;
    repeat (3) @(posedge clk);
    #1;
    // R2 / R8 reset state
    n_checks++;
    if (ref_code != '0 || sw_en || ss_active || done) begin
      n_errors++;
      $display("FAIL R2 reset: code=%0d sw=%0b ss=%0b done=%0b expected all 0",
               ref_code, sw_en, ss_active, done);
    end
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    cur_tag = "R2 supply only";
    run(20, 1, 0, 0, 0, 0, 3);
    cur_tag = "R2 enable only";
    run(20, 0, 1, 0, 0, 0, 3);

    cur_tag = "R1 R8 full ramp";
    run(300, 1, 1, 0, 0, 0, 3);
    cur_tag = "R9 no ticks";
    run(40, 1, 1, 0, 0, 0, 0);
    cur_tag = "R1 R8 full ramp";
    run_to_done(0);

    cur_tag = "R5 overload in regulate";
    run(20, 1, 1, 0, 1, 0, 3);
    cur_tag = "R6 recovery from 1500";
    run_to_done(1500);

    cur_tag = "R3 disable mid-ramp";
    run(2, 1, 1, 0, 0, 0, 0);
    run(10, 1, 0, 0, 0, 0, 3);
    run(3, 0, 1, 0, 0, 0, 3);
    run(400, 1, 1, 0, 0, 0, 3);
    run(5, 0, 0, 0, 0, 0, 3);
    cur_tag = "R3 restart from zero";
    run(200, 1, 1, 0, 0, 0, 3);

    cur_tag = "R5 overload mid-ramp";
    run(25, 1, 1, 0, 1, 200, 3);
    cur_tag = "R6 recovery from 200";
    run_to_done(200);

    cur_tag = "R4 thermal mid-ramp";
    run(3, 1, 0, 0, 0, 0, 0);
    run(300, 1, 1, 0, 0, 0, 3);
    run(15, 1, 1, 1, 0, 0, 3);
    cur_tag = "R4 fresh ramp after thermal";
    run_to_done(0);

    cur_tag = "R7 sense above reference";
    run(5, 1, 1, 0, 1, 4095, 3);
    run(10, 1, 1, 0, 0, 4095, 3);
    cur_tag = "R7 sense at reference";
    run(5, 1, 1, 0, 1, REF, 3);
    run(6, 1, 1, 0, 0, REF, 3);

    cur_tag = "R4 thermal while off";
    run(5, 1, 0, 1, 0, 0, 3);
    run(3, 1, 1, 1, 0, 0, 3);
    run(30, 1, 1, 0, 0, 0, 3);

    repeat (3) @(negedge clk);
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
      $finish;
    end
  end

endmodule